// File: doc/BRIEF.md
# Reorder Buffer with Precise Recovery

This block is the in-order retirement window of an out-of-order core. Instructions enter at the tail in program order and receive a tag. Execution units write results and exception codes back by that tag, in any order. Resolved branches are reported by tag. The oldest entry at the head retires into a 32-entry architectural register file only when it has finished cleanly. The register file therefore always holds the state that a purely sequential machine would have at that point.

There are two recovery paths. In the first, the head entry finishes with a nonzero exception code. The whole window is then emptied without touching the register file, and the PC of that entry is returned as the restart point. In the second, a branch resolves as mispredicted. Every entry younger than the branch is then dropped, the tail is pulled back to the slot after the branch, and the corrected target is returned. The branch itself stays and retires normally. Both paths raise a single-cycle flush. Allocation is refused in that cycle.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `alloc_tag` is 0, `commit_valid` and `flush` are 0, and every register in the register file reads 0.
- R2: Accepted allocations receive consecutive tags modulo the depth (16). With 16 entries occupied, `alloc_ready` is 0 and a request is not accepted.
- R3: The head entry retires only when it is valid and done with exception code 0, at most one per cycle and strictly in order. An entry that finished early waits behind an unfinished older one. When the entry's write-enable is set, its result is written to register `rd`.
- R4: If the head entry is done with a nonzero 4-bit code, `flush` and `flush_exc` are 1 in that same cycle and `redirect_pc` is that entry's PC. Nothing retires, the register file is unchanged, and the buffer is empty in the next cycle.
- R5: A mispredicted resolve to a valid entry raises `flush` (with `flush_exc` 0) in that cycle, with `redirect_pc` equal to `br_target`. Every younger entry is discarded, the next tag handed out is the branch tag plus 1, and the branch later retires.
- R6: A correctly predicted resolve marks the branch done without raising `flush`.
- R7: A completion sent to a tag whose entry is not valid, such as a discarded one, has no effect. A later instruction allocated into that slot still waits for its own completion.
- R8: `alloc_ready` is 0 in every cycle in which `flush` is 1.
- R9: If an excepting head and a mispredict resolve occur in the same cycle, the exception wins: `flush_exc` is 1 and `redirect_pc` is the head PC.
- R10: Register 0 always reads 0, even after an instruction that writes register 0 retires.
- R11: `alloc_spec` is 1 exactly when some valid branch entry has not yet been resolved. An instruction allocated in that cycle is therefore speculative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_pc | input | 32 | PC of the allocated instruction |
| alloc_rd | input | 5 | Destination register number |
| alloc_wr_en | input | 1 | Instruction writes `alloc_rd` at retirement |
| alloc_is_br | input | 1 | Instruction is a branch, completed through the resolve port |
| alloc_ready | output | 1 | Allocation is accepted this cycle |
| alloc_tag | output | 4 | Tag given to the instruction allocated this cycle |
| alloc_spec | output | 1 | An older branch is still unresolved |
| cmp_valid | input | 1 | Completion write |
| cmp_tag | input | 4 | Tag of the completing entry |
| cmp_data | input | 32 | Result value |
| cmp_exc | input | 4 | Exception code; 0 means none |
| br_valid | input | 1 | Branch resolution |
| br_tag | input | 4 | Tag of the resolved branch |
| br_mispredict | input | 1 | Branch was mispredicted |
| br_target | input | 32 | Correct-path PC |
| commit_valid | output | 1 | Head entry retires this cycle |
| commit_we | output | 1 | Retiring entry writes the register file |
| commit_rd | output | 5 | Destination of the retiring entry |
| commit_data | output | 32 | Result of the retiring entry |
| flush | output | 1 | Recovery pulse |
| flush_exc | output | 1 | Recovery caused by an exception (0 for a mispredict) |
| redirect_pc | output | 32 | Restart PC during `flush` |
| arf_raddr | input | 5 | Register file read address |
| arf_rdata | output | 32 | Register file read data |

## Verification
Several events can land in the same cycle: an exception at the head can coincide with a mispredict resolve on a younger branch, and a mispredict can coincide with the head retiring. A directed case places an exception on the oldest entry, then resolves a younger branch as mispredicted in the exact cycle that the exception becomes visible. It is judged by `flush_exc`, `redirect_pc` and an empty buffer in the next cycle. The random phase then mixes retirement, completion, resolution and allocation every cycle. Each cycle is compared against a bench-side model of tag occupancy, so that tail rollback combined with a head advance is checked through the next `alloc_tag`.

// File: rtl/rob_pkg.sv
package rob_pkg;
   // Reason for a recovery pulse
   typedef enum logic [1:0] {
      RCV_NONE = 2'd0,
      RCV_EXC  = 2'd1,
      RCV_MISP = 2'd2
   } rcv_cause_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_fire,
   input  logic          retire_fire,
   input  logic          rcv_exc,
   input  logic          rcv_misp,
   input  logic [AW-1:0] misp_idx,
   output logic [AW-1:0] head_idx,
   output logic [AW-1:0] tail_idx,
   output logic          full,
   output logic          empty
);
   // pointers carry one extra wrap bit
   logic [AW:0]   head_q, tail_q;
   logic [AW-1:0] misp_dist;
   logic [AW:0]   misp_tail;

   assign head_idx  = head_q[AW-1:0];
   assign tail_idx  = tail_q[AW-1:0];
   assign empty     = (head_q == tail_q);
   assign full      = (head_q[AW] != tail_q[AW]) && (head_q[AW-1:0] == tail_q[AW-1:0]);
   assign misp_dist = misp_idx - head_q[AW-1:0];
   assign misp_tail = head_q + {1'b0, misp_dist} + {{AW{1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         if (retire_fire)
            head_q <= head_q + {{AW{1'b0}}, 1'b1};
         if (rcv_exc)
            tail_q <= head_q;
         else if (rcv_misp)
            tail_q <= misp_tail;
         else if (alloc_fire)
            tail_q <= tail_q + {{AW{1'b0}}, 1'b1};
      end
   end
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
   parameter int DEPTH = 16,
   parameter int PC_W  = 32,
   parameter int XLEN  = 32,
   parameter int RW    = 5,
   parameter int EXC_W = 4,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_fire,
   input  logic [AW-1:0]    alloc_idx,
   input  logic [PC_W-1:0]  alloc_pc,
   input  logic [RW-1:0]    alloc_rd,
   input  logic             alloc_we,
   input  logic             alloc_br,
   input  logic             cmp_valid,
   input  logic [AW-1:0]    cmp_idx,
   input  logic [XLEN-1:0]  cmp_data,
   input  logic [EXC_W-1:0] cmp_exc,
   input  logic             res_valid,
   input  logic [AW-1:0]    res_idx,
   input  logic [DEPTH-1:0] kill_mask,
   input  logic             retire_fire,
   input  logic [AW-1:0]    head_idx,
   output logic [DEPTH-1:0] valid_vec,
   output logic             head_valid,
   output logic             head_done,
   output logic [EXC_W-1:0] head_exc,
   output logic [PC_W-1:0]  head_pc,
   output logic [RW-1:0]    head_rd,
   output logic             head_we,
   output logic [XLEN-1:0]  head_data,
   output logic             unresolved_any
);
   logic [DEPTH-1:0] valid_q, done_q, we_q, br_q;
   logic [EXC_W-1:0] exc_q  [DEPTH];
   logic [PC_W-1:0]  pc_q   [DEPTH];
   logic [RW-1:0]    rd_q   [DEPTH];
   logic [XLEN-1:0]  data_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         done_q  <= '0;
         we_q    <= '0;
         br_q    <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            exc_q[i]  <= '0;
            pc_q[i]   <= '0;
            rd_q[i]   <= '0;
            data_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (alloc_fire && alloc_idx == AW'(i)) begin
               valid_q[i] <= 1'b1;
               done_q[i]  <= 1'b0;
               exc_q[i]   <= '0;
               pc_q[i]    <= alloc_pc;
               rd_q[i]    <= alloc_rd;
               we_q[i]    <= alloc_we;
               br_q[i]    <= alloc_br;
               data_q[i]  <= '0;
            end else begin
               // writebacks only land on live entries
               if (valid_q[i] && cmp_valid && cmp_idx == AW'(i)) begin
                  done_q[i] <= 1'b1;
                  exc_q[i]  <= cmp_exc;
                  data_q[i] <= cmp_data;
               end
               if (valid_q[i] && res_valid && res_idx == AW'(i))
                  done_q[i] <= 1'b1;
               if (kill_mask[i] || (retire_fire && head_idx == AW'(i)))
                  valid_q[i] <= 1'b0;
            end
         end
      end
   end

   assign valid_vec      = valid_q;
   assign head_valid     = valid_q[head_idx];
   assign head_done      = done_q[head_idx];
   assign head_exc       = exc_q[head_idx];
   assign head_pc        = pc_q[head_idx];
   assign head_rd        = rd_q[head_idx];
   assign head_we        = we_q[head_idx];
   assign head_data      = data_q[head_idx];
   assign unresolved_any = |(valid_q & br_q & ~done_q);
endmodule

// File: rtl/rob_arf.sv
module rob_arf #(
   parameter int NREG    = 32,
   parameter int XLEN    = 32,
   parameter bit ZERO_R0 = 1'b1,
   localparam int RW     = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [RW-1:0]   waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [RW-1:0]   raddr,
   output logic [XLEN-1:0] rdata
);
   logic [XLEN-1:0] regs [NREG];

   generate
      if (ZERO_R0) begin : g_zero_r0
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NREG; i++) regs[i] <= '0;
            end else if (we && waddr != '0) begin
               regs[waddr] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NREG; i++) regs[i] <= '0;
            end else if (we) begin
               regs[waddr] <= wdata;
            end
         end
      end
   endgenerate

   assign rdata = regs[raddr];
endmodule

// File: rtl/rob_core.sv
module rob_core #(
   parameter int DEPTH     = 16,
   parameter int NUM_AREGS = 32,
   parameter int XLEN      = 32,
   parameter int PC_W      = 32,
   parameter int EXC_W     = 4,
   parameter bit ZERO_R0   = 1'b1,
   localparam int AW       = $clog2(DEPTH),
   localparam int RW       = $clog2(NUM_AREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_valid,
   input  logic [PC_W-1:0]  alloc_pc,
   input  logic [RW-1:0]    alloc_rd,
   input  logic             alloc_wr_en,
   input  logic             alloc_is_br,
   output logic             alloc_ready,
   output logic [AW-1:0]    alloc_tag,
   output logic             alloc_spec,
   input  logic             cmp_valid,
   input  logic [AW-1:0]    cmp_tag,
   input  logic [XLEN-1:0]  cmp_data,
   input  logic [EXC_W-1:0] cmp_exc,
   input  logic             br_valid,
   input  logic [AW-1:0]    br_tag,
   input  logic             br_mispredict,
   input  logic [PC_W-1:0]  br_target,
   output logic             commit_valid,
   output logic             commit_we,
   output logic [RW-1:0]    commit_rd,
   output logic [XLEN-1:0]  commit_data,
   output logic             flush,
   output logic             flush_exc,
   output logic [PC_W-1:0]  redirect_pc,
   input  logic [RW-1:0]    arf_raddr,
   output logic [XLEN-1:0]  arf_rdata
);
   import rob_pkg::*;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rob_core: DEPTH must be a power of two >= 2");
      end
      if (NUM_AREGS < 2 || (NUM_AREGS & (NUM_AREGS - 1)) != 0) begin : g_bad_regs
         $error("rob_core: NUM_AREGS must be a power of two >= 2");
      end
      if (EXC_W < 1) begin : g_bad_exc
         $error("rob_core: EXC_W must be at least 1");
      end
   endgenerate

   logic [AW-1:0]    head_idx, tail_idx;
   logic             full_w, empty_w;
   logic [DEPTH-1:0] valid_vec, kill_mask;
   logic             head_valid, head_done, head_we, unres_any;
   logic [EXC_W-1:0] head_exc;
   logic [PC_W-1:0]  head_pc;
   logic [RW-1:0]    head_rd;
   logic [XLEN-1:0]  head_data;
   logic             head_finished, exc_at_head, retire_fire, br_hit, misp_w, alloc_fire;
   logic [AW-1:0]    br_age;
   rcv_cause_e       cause;

   assign head_finished = head_valid && head_done;
   assign exc_at_head   = head_finished && (head_exc != '0);
   assign retire_fire   = head_finished && (head_exc == '0);
   assign br_hit        = br_valid && valid_vec[br_tag];
   // an excepting head is older than any branch, so it takes precedence
   assign misp_w        = br_hit && br_mispredict && !exc_at_head;

   always_comb begin
      cause = RCV_NONE;
      if (exc_at_head) cause = RCV_EXC;
      else if (misp_w) cause = RCV_MISP;
   end

   assign flush       = (cause != RCV_NONE);
   assign flush_exc   = (cause == RCV_EXC);
   assign redirect_pc = (cause == RCV_EXC)  ? head_pc :
                        (cause == RCV_MISP) ? br_target : '0;

   assign alloc_ready = !full_w && !flush;
   assign alloc_fire  = alloc_valid && alloc_ready;
   assign alloc_tag   = tail_idx;
   assign alloc_spec  = unres_any;

   assign commit_valid = retire_fire;
   assign commit_we    = retire_fire && head_we;
   assign commit_rd    = head_rd;
   assign commit_data  = head_data;

   assign br_age = br_tag - head_idx;

   for (genvar g = 0; g < DEPTH; g++) begin : g_kill
      logic [AW-1:0] age_g;
      assign age_g        = AW'(g) - head_idx;
      assign kill_mask[g] = (cause == RCV_EXC) || ((cause == RCV_MISP) && (age_g > br_age));
   end

   rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_fire  (alloc_fire),
      .retire_fire (retire_fire),
      .rcv_exc     (cause == RCV_EXC),
      .rcv_misp    (cause == RCV_MISP),
      .misp_idx    (br_tag),
      .head_idx    (head_idx),
      .tail_idx    (tail_idx),
      .full        (full_w),
      .empty       (empty_w)
   );

   rob_entry_store #(
      .DEPTH(DEPTH), .PC_W(PC_W), .XLEN(XLEN), .RW(RW), .EXC_W(EXC_W)
   ) u_store (
      .clk            (clk),
      .rst_n          (rst_n),
      .alloc_fire     (alloc_fire),
      .alloc_idx      (tail_idx),
      .alloc_pc       (alloc_pc),
      .alloc_rd       (alloc_rd),
      .alloc_we       (alloc_wr_en),
      .alloc_br       (alloc_is_br),
      .cmp_valid      (cmp_valid),
      .cmp_idx        (cmp_tag),
      .cmp_data       (cmp_data),
      .cmp_exc        (cmp_exc),
      .res_valid      (br_hit),
      .res_idx        (br_tag),
      .kill_mask      (kill_mask),
      .retire_fire    (retire_fire),
      .head_idx       (head_idx),
      .valid_vec      (valid_vec),
      .head_valid     (head_valid),
      .head_done      (head_done),
      .head_exc       (head_exc),
      .head_pc        (head_pc),
      .head_rd        (head_rd),
      .head_we        (head_we),
      .head_data      (head_data),
      .unresolved_any (unres_any)
   );

   rob_arf #(.NREG(NUM_AREGS), .XLEN(XLEN), .ZERO_R0(ZERO_R0)) u_arf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (commit_we),
      .waddr (head_rd),
      .wdata (head_data),
      .raddr (arf_raddr),
      .rdata (arf_rdata)
   );
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          alloc_valid,
   input logic          alloc_ready,
   input logic [AW-1:0] alloc_tag,
   input logic [AW-1:0] br_tag,
   input logic          commit_valid,
   input logic          flush,
   input logic          flush_exc,
   input logic          empty,
   input logic [AW-1:0] head_idx
);
   // R2
   alloc_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && alloc_ready) |=> !empty);

   // R3
   head_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |=> (head_idx == AW'($past(head_idx) + 1'b1)));

   // R4
   exc_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && flush_exc) |=> empty);

   // R4
   exc_no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && flush_exc) |-> !commit_valid);

   // R5
   misp_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !flush_exc) |=> (alloc_tag == AW'($past(br_tag) + 1'b1)));
endmodule

bind rob_core rob_core_chk #(.AW(AW)) u_rob_core_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .alloc_valid  (alloc_valid),
   .alloc_ready  (alloc_ready),
   .alloc_tag    (alloc_tag),
   .br_tag       (br_tag),
   .commit_valid (commit_valid),
   .flush        (flush),
   .flush_exc    (flush_exc),
   .empty        (empty_w),
   .head_idx     (head_idx)
);

// File: tb/rob_core_bench.sv
module rob_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_v = 0, a_we = 0, a_br = 0;
   logic [31:0] a_pc = '0;
   logic [4:0]  a_rd = '0;
   logic        c_v = 0;
   logic [3:0]  c_tag = '0, c_exc = '0;
   logic [31:0] c_data = '0;
   logic        b_v = 0, b_mis = 0;
   logic [3:0]  b_tag = '0;
   logic [31:0] b_tgt = '0;
   logic [4:0]  rd_addr = '0;

   logic        alloc_ready, alloc_spec, commit_valid, commit_we, flush, flush_exc;
   logic [3:0]  alloc_tag;
   logic [4:0]  commit_rd;
   logic [31:0] commit_data, redirect_pc, arf_rdata;

   always #2 clk = ~clk;

   rob_core u_rob_core (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(a_v), .alloc_pc(a_pc), .alloc_rd(a_rd), .alloc_wr_en(a_we), .alloc_is_br(a_br),
      .alloc_ready(alloc_ready), .alloc_tag(alloc_tag), .alloc_spec(alloc_spec),
      .cmp_valid(c_v), .cmp_tag(c_tag), .cmp_data(c_data), .cmp_exc(c_exc),
      .br_valid(b_v), .br_tag(b_tag), .br_mispredict(b_mis), .br_target(b_tgt),
      .commit_valid(commit_valid), .commit_we(commit_we), .commit_rd(commit_rd),
      .commit_data(commit_data), .flush(flush), .flush_exc(flush_exc),
      .redirect_pc(redirect_pc), .arf_raddr(rd_addr), .arf_rdata(arf_rdata)
   );

   int n_chk = 0, n_fail = 0;

   // bench model of the window
   bit          m_v[16], m_d[16], m_we[16], m_br[16];
   logic [3:0]  m_exc[16];
   logic [31:0] m_pc[16], m_data[16];
   logic [4:0]  m_rd[16];
   logic [31:0] m_arf[32];
   int          m_head = 0, m_cnt = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic clr();
      a_v = 0; a_we = 0; a_br = 0; c_v = 0; c_exc = 0; b_v = 0; b_mis = 0;
   endtask

   // inputs are set; check outputs mid-cycle, then mirror the clock edge in the model
   task automatic tick();
      int h, ab, tl;
      bit live, e_exc, e_com, bhit, e_mis, e_fl, e_rdy, e_spec, afire;
      logic [31:0] e_red;
      string lab;
      #1;
      h     = m_head;
      live  = m_v[h] && m_d[h];
      e_exc = live && (m_exc[h] != 0);
      e_com = live && (m_exc[h] == 0);
      bhit  = b_v && m_v[b_tag];
      e_mis = bhit && b_mis && !e_exc;
      e_fl  = e_exc || e_mis;
      e_rdy = (m_cnt < 16) && !e_fl;
      e_red = e_exc ? m_pc[h] : (e_mis ? b_tgt : 32'h0);
      e_spec = 0;
      for (int j = 0; j < 16; j++) if (m_v[j] && m_br[j] && !m_d[j]) e_spec = 1;
      tl = (h + m_cnt) % 16;

      lab = e_fl ? "R8" : "R2";
      chk(alloc_ready === e_rdy, lab, alloc_ready, e_rdy);
      if (e_rdy) chk(alloc_tag === 4'(tl), "R2", alloc_tag, tl);
      chk(commit_valid === e_com, "R3", commit_valid, e_com);
      if (e_com) begin
         chk(commit_we === m_we[h], "R3", commit_we, m_we[h]);
         if (m_we[h]) begin
            chk(commit_rd === m_rd[h], "R3", commit_rd, m_rd[h]);
            chk(commit_data === m_data[h], "R3", commit_data, m_data[h]);
         end
      end
      lab = e_exc ? ((b_v && b_mis && bhit) ? "R9" : "R4") : (e_mis ? "R5" : (bhit ? "R6" : "R3"));
      chk(flush === e_fl, lab, flush, e_fl);
      if (e_fl) begin
         chk(redirect_pc === e_red, lab, redirect_pc, e_red);
         chk(flush_exc === e_exc, lab, flush_exc, e_exc);
      end
      chk(alloc_spec === e_spec, "R11", alloc_spec, e_spec);

      @(posedge clk);
      afire = a_v && e_rdy;
      ab = (int'(b_tag) - h + 16) % 16;
      if (c_v && m_v[c_tag]) begin
         m_d[c_tag] = 1; m_exc[c_tag] = c_exc; m_data[c_tag] = c_data;
      end
      if (bhit) m_d[b_tag] = 1;
      if (e_exc) begin
         for (int j = 0; j < 16; j++) m_v[j] = 0;
         m_cnt = 0;
      end else begin
         if (e_mis) begin
            for (int j = 0; j < 16; j++) if (((j - h + 16) % 16) > ab) m_v[j] = 0;
            m_cnt = ab + 1;
         end
         if (e_com) begin
            if (m_we[h] && m_rd[h] != 0) m_arf[m_rd[h]] = m_data[h];
            m_v[h] = 0; m_head = (h + 1) % 16; m_cnt--;
         end
         if (afire) begin
            m_v[tl] = 1; m_d[tl] = 0; m_exc[tl] = 0; m_pc[tl] = a_pc;
            m_rd[tl] = a_rd; m_we[tl] = a_we; m_br[tl] = a_br; m_data[tl] = 0;
            m_cnt++;
         end
      end
      #1;
   endtask

   function automatic int next_tag(input int k);
      return (m_head + m_cnt + k) % 16;
   endfunction

   task automatic do_alloc(input logic [31:0] pc, input logic [4:0] rd, input bit we, input bit br);
      clr(); a_v = 1; a_pc = pc; a_rd = rd; a_we = we; a_br = br; tick(); clr();
   endtask

   task automatic do_cmp(input int tag, input logic [31:0] d, input logic [3:0] e);
      clr(); c_v = 1; c_tag = 4'(tag); c_data = d; c_exc = e; tick(); clr();
   endtask

   task automatic do_res(input int tag, input bit mis, input logic [31:0] tgt);
      clr(); b_v = 1; b_tag = 4'(tag); b_mis = mis; b_tgt = tgt; tick(); clr();
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin clr(); tick(); end
   endtask

   task automatic drain();
      for (int guard = 0; guard < 200 && m_cnt != 0; guard++) begin
         int t;
         clr();
         t = -1;
         for (int j = 0; j < 16; j++) begin
            int idx;
            idx = (m_head + j) % 16;
            if (t < 0 && j < m_cnt && m_v[idx] && !m_d[idx]) t = idx;
         end
         if (t >= 0) begin
            if (m_br[t]) begin b_v = 1; b_tag = 4'(t); b_mis = 0; end
            else begin c_v = 1; c_tag = 4'(t); c_data = $urandom; c_exc = 0; end
         end
         tick();
      end
      clr();
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL R3 watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int t0, dummy;
      dummy = $urandom(32'd7741);
      for (int j = 0; j < 32; j++) m_arf[j] = 0;
      for (int j = 0; j < 16; j++) begin
         m_v[j] = 0; m_d[j] = 0; m_we[j] = 0; m_br[j] = 0;
         m_exc[j] = 0; m_pc[j] = 0; m_data[j] = 0; m_rd[j] = 0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      #1;
      // R1 reset state
      chk(alloc_ready === 1'b1, "R1", alloc_ready, 1);
      chk(alloc_tag === 4'd0, "R1", alloc_tag, 0);
      chk(commit_valid === 1'b0, "R1", commit_valid, 0);
      chk(flush === 1'b0, "R1", flush, 0);
      rd_addr = 5'd9; #0.5;
      chk(arf_rdata === 32'h0, "R1", arf_rdata, 0);
      @(posedge clk); #1;

      // R2 fill the window, seventeenth request refused
      for (int k = 0; k < 17; k++) do_alloc(32'h1000 + 4 * k, 5'(k + 1), 1, 0);
      chk(m_cnt == 16, "R2", m_cnt, 16);
      // R3 finish out of order, retire in order
      for (int k = 15; k >= 0; k--) do_cmp((m_head + k) % 16, 32'hA000 + k, 0);
      idle(17);

      // R4 exception on the second entry
      t0 = next_tag(0);
      do_alloc(32'h2000, 5'd3, 1, 0);
      do_alloc(32'h2004, 5'd4, 1, 0);
      do_alloc(32'h2008, 5'd5, 1, 0);
      do_cmp((t0 + 2) % 16, 32'hBAD2, 0);
      do_cmp((t0 + 1) % 16, 32'hBAD1, 4'h6);
      do_cmp(t0, 32'h00C0, 0);
      idle(3);
      chk(m_cnt == 0, "R4", m_cnt, 0);

      // R5 and R7 mispredict, completion to a discarded tag, reuse of the slot
      t0 = next_tag(0);
      do_alloc(32'h3000, 5'd0, 0, 1);
      do_alloc(32'h3004, 5'd6, 1, 0);
      do_alloc(32'h3008, 5'd7, 1, 0);
      do_res(t0, 1, 32'h3100);
      do_cmp((t0 + 1) % 16, 32'hDEAD, 0);
      do_alloc(32'h3100, 5'd8, 1, 0);
      idle(2);
      chk(commit_valid === 1'b0, "R7", commit_valid, 0);
      drain();

      // R6 correct resolve, no flush
      t0 = next_tag(0);
      do_alloc(32'h4000, 5'd0, 0, 1);
      do_alloc(32'h4004, 5'd9, 1, 0);
      do_res(t0, 0, 32'h0);
      drain();

      // R9 exception and mispredict in the same cycle
      t0 = next_tag(0);
      do_alloc(32'h5000, 5'd10, 1, 0);
      do_alloc(32'h5004, 5'd0, 0, 1);
      do_alloc(32'h5008, 5'd11, 1, 0);
      do_cmp(t0, 32'h55, 4'h2);
      do_res((t0 + 1) % 16, 1, 32'h5200);
      idle(1);

      // R10 write to register 0
      t0 = next_tag(0);
      do_alloc(32'h6000, 5'd0, 1, 0);
      do_cmp(t0, 32'hFFFF_0000, 0);
      idle(2);

      // random mix
      for (int cyc = 0; cyc < 4000; cyc++) begin
         int t, t2;
         clr();
         a_v = ($urandom % 3) != 0;
         a_pc = $urandom; a_rd = 5'($urandom); a_br = ($urandom % 5) == 0;
         a_we = !a_br && (($urandom % 4) != 0);
         t = $urandom % 16;
         c_v = (($urandom % 2) == 1) && !(m_v[t] && (m_br[t] || m_d[t]));
         c_tag = 4'(t); c_data = $urandom;
         c_exc = (($urandom % 24) == 0) ? 4'(1 + $urandom % 15) : 4'h0;
         t2 = $urandom % 16;
         b_v = m_v[t2] && m_br[t2] && !m_d[t2] && (($urandom % 3) == 0);
         b_tag = 4'(t2); b_mis = ($urandom % 3) == 0; b_tgt = $urandom;
         tick();
      end
      drain();

      // R3 and R10 final register file contents
      for (int r = 0; r < 32; r++) begin
         rd_addr = 5'(r); #0.5;
         chk(arf_rdata === m_arf[r], (r == 0) ? "R10" : "R3", arf_rdata, m_arf[r]);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule